// File: doc/BRIEF.md
# Two-Tone DAC Formatter with Delayed Capture Trigger

This glue block takes two signed 13-bit tone samples, adds them into a 14-bit composite word without any risk of overflow, and hands that word to a unipolar DAC. The DAC expects unsigned codes, so the composite is moved into offset-binary form by flipping its top bit. The result is held in an output register so that the path from clock to pins is a single flop.

The block also holds a counter that advances only while a clock enable is high. It raises `count_reached` when the count hits its terminal value. The falling edge of that flag becomes a one-cycle capture strobe for an on-chip logic analyzer. Reset is pulsed before the enable goes high, so the first strobe cannot appear until a full period of enabled cycles has gone by. The analog path settles during that wait.

Top module: `tone_dac_glue`

## Requirements
- R1: `mix_sum` is the two's-complement sum of `tone_a` and `tone_b`, each sign-extended to 14 bits. Every pair of 13-bit inputs, including both full-scale extremes, gives the exact result without overflow.
- R2: One clock edge after any non-reset cycle, `dac_code` equals the previous cycle's `mix_sum` plus 8192 modulo 16384. This means bit 13 is inverted and bits 12..0 are unchanged, so -8192 maps to 0, 0 to 8192 and 8190 to 16382.
- R3: The internal count changes only on edges where `clken` is high. While `clken` stays low after reset, `count_reached` stays low.
- R4: The count runs 0,1,...,PERIOD-1 and then wraps to 0, with PERIOD = 4095 by default. `count_reached` is high exactly while the count equals PERIOD-1. With `clken` held high, it is therefore high for one cycle in every PERIOD cycles.
- R5: `trig_strobe` is high for exactly one cycle, in the cycle after `count_reached` falls from 1 to 0. It is never high on two consecutive cycles.
- R6: The first `trig_strobe` after reset appears only after exactly PERIOD enabled edges have passed, and never earlier.
- R7: Synchronous active-high `rst` clears the count, the edge-detect flop and the DAC register. In the cycle after reset, `dac_code`, `count_reached` and `trig_strobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clken | input | 1 | Counter advance enable |
| tone_a | input | 13 | First signed tone sample |
| tone_b | input | 13 | Second signed tone sample |
| mix_sum | output | 14 | Signed composite sum (combinational) |
| dac_code | output | 14 | Registered offset-binary DAC word |
| count_reached | output | 1 | High while the counter sits at its terminal value |
| trig_strobe | output | 1 | One-cycle capture strobe on the falling edge of count_reached |

## Verification
The assertions assume that `rst` is held high from time zero for at least one edge. They also assume that the tone inputs are stable across each rising edge, so a sampled sum is well defined. The stimulus sweeps both tones over a 33-by-33 grid that includes both full-scale ends, changing them only on falling edges. It then runs the counter through several periods with `clken` dropped in a fixed pattern and held low at the terminal count, so that pauses land both mid-count and at the edge-detect boundary.

// File: rtl/tone_dac_glue.sv
module tone_dac_glue #(
  parameter int SAMPLE_W = 13,
  parameter int PERIOD   = 4095
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clken,
  input  logic [SAMPLE_W-1:0]   tone_a,
  input  logic [SAMPLE_W-1:0]   tone_b,
  output logic [SAMPLE_W:0]     mix_sum,
  output logic [SAMPLE_W:0]     dac_code,
  output logic                  count_reached,
  output logic                  trig_strobe
);
  localparam int SUM_W = SAMPLE_W + 1;
  localparam int CW    = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          reached_q;

  assign mix_sum = {tone_a[SAMPLE_W-1], tone_a} + {tone_b[SAMPLE_W-1], tone_b};

  always_ff @(posedge clk) begin
    if (rst) dac_code <= '0;
    else     dac_code <= {~mix_sum[SUM_W-1], mix_sum[SUM_W-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (clken)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign count_reached = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) reached_q <= 1'b0;
    else     reached_q <= count_reached;
  end

  assign trig_strobe = reached_q & ~count_reached;

  // checker state: enabled edges since reset, saturating
  logic [CW:0] en_seen;
  always_ff @(posedge clk) begin
    if (rst)                                   en_seen <= '0;
    else if (clken && en_seen != (CW+1)'(PERIOD)) en_seen <= en_seen + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (tone_a[SAMPLE_W-1] == tone_b[SAMPLE_W-1]) |-> (mix_sum[SUM_W-1] == tone_a[SAMPLE_W-1])); // R1
  AST_DAC_OFFSET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dac_code == SUM_W'($past($signed(tone_a)) + $past($signed(tone_b)) + (1 <<< (SUM_W-1)))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !clken |=> $stable(cnt)); // R3
  AST_REACH_ONCE: assert property (@(posedge clk) disable iff (rst)
    (count_reached && clken) |=> !count_reached); // R4
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trig_strobe |=> !trig_strobe); // R5
  AST_TRIG_DELAY: assert property (@(posedge clk) disable iff (rst)
    trig_strobe |-> (en_seen == (CW+1)'(PERIOD)) && (cnt == '0)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (dac_code == '0) && !count_reached && !trig_strobe); // R7
endmodule

// File: tb/tone_dac_glue_tb_top.sv
module tone_dac_glue_tb_top;
  localparam int PERIOD = 4095;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clken = 1'b0;
  logic [12:0] tone_a = '0, tone_b = '0;
  logic [13:0] mix_sum, dac_code;
  logic count_reached, trig_strobe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tone_dac_glue dut_i (
    .clk(clk), .rst(rst), .clken(clken), .tone_a(tone_a), .tone_b(tone_b),
    .mix_sum(mix_sum), .dac_code(dac_code),
    .count_reached(count_reached), .trig_strobe(trig_strobe));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    bit last_en;
    bit seen_trig;
    int paused;

    repeat (3) @(negedge clk);
    chk("R7 dac_code", dac_code, 0);
    chk("R7 count_reached", count_reached, 0);
    chk("R7 trig_strobe", trig_strobe, 0);
    rst = 1'b0;

    // R1/R2 sweep with clken low (R3 idle check alongside)
    for (int ia = 0; ia <= 32; ia++) begin
      for (int ib = 0; ib <= 32; ib++) begin
        int a = (ia == 32) ? 4095 : -4096 + ia * 256;
        int b = (ib == 32) ? 4095 : -4096 + ib * 256;
        int s = a + b;
        tone_a = 13'(a);
        tone_b = 13'(b);
        #1;
        chk("R1 mix_sum", int'($signed(mix_sum)), s);
        @(negedge clk);
        chk("R2 dac_code", int'(dac_code), (s + 8192) & 16383);
        chk("R3 idle count_reached", count_reached, 0);
      end
    end

    // restart counter from reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R7 post-reset count_reached", count_reached, 0);
    chk("R7 post-reset trig_strobe", trig_strobe, 0);

    n = 0; last_en = 0; seen_trig = 0; paused = 0;
    for (int k = 0; k < 3 * PERIOD + 800; k++) begin
      bit en;
      bit exp_trig;
      exp_trig = last_en && n > 0 && (n % PERIOD == 0);
      chk("R4 count_reached", count_reached, int'(n % PERIOD == PERIOD - 1));
      chk("R5 trig_strobe", trig_strobe, int'(exp_trig));
      if (trig_strobe && !seen_trig) begin
        seen_trig = 1;
        chk("R6 first trigger enabled edges", n, PERIOD);
      end
      if (n % PERIOD == 0) paused = 0;
      en = (k % 7 != 3) && !(n % PERIOD == PERIOD - 1 && paused < 3);
      if (n % PERIOD == PERIOD - 1 && !en) paused++;
      clken = en;
      @(negedge clk);
      if (en) n++;
      last_en = en;
    end
    chk("R6 trigger observed", int'(seen_trig), 1);
    clken = 1'b0;
    finish_run();
  end
endmodule